// File: doc/BRIEF.md
# Serial Master with Programmable Inter-Byte Gap

This block is a three-wire clocked serial port that can act as clock master or as slave. As master it derives a serial clock from a divisor input. It shifts one byte out on the data-out line while it shifts one byte in from the data-in line. After each byte it holds the serial clock idle for a programmable number of serial-clock periods. Once that gap has run out it either starts the next byte of an automatic burst or raises a one-cycle completion interrupt.

The gap comes from a 6-bit interval register that reads back as an 8-bit value. Two enables set a floor under the gap: a strobe enable and a busy enable. The gap actually used is the larger of the programmed interval and that floor, so a floor applies even when the interval register holds zero. Transfers run back to back with no gap only when the interval is zero and both enables are off. In slave mode the clock comes in from outside, and no gap is inserted.

Top module: `sio_gap_master`

## Requirements
- R1: After reset the interval reads 0x00, the busy flag and the interrupt are low, and the serial clock output is high.
- R2: A write stores a 6-bit interval value. The 8-bit readback returns that value in bits 5:0 with bits 7:6 at zero.
- R3: A write to the interval register is ignored while the busy flag is 1.
- R4: In master mode the serial clock period is 2*(D+1) system clocks, where D is the divisor input. A single-byte transfer accepted at clock edge S raises the interrupt at edge S + 2*(D+1)*(8+E), where E is the effective gap in serial-clock periods.
- R5: Data moves MSB first. The data-out line changes only on falling serial-clock edges, and data-in is sampled on rising edges. When the interrupt is raised, the receive output holds the byte received.
- R6: E = max(interval, floor). The floor is 2 when strobe is enabled, whatever the busy enable says. It is 1 when only busy is enabled, and 0 when neither is enabled.
- R7: With interval 0 and both enables off, E = 0, and a byte takes exactly 16*(D+1) system clocks from start to interrupt.
- R8: In automatic mode N = byte-count + 1 bytes are sent, with gap E after every byte including the last. A single interrupt comes at edge S + N*2*(D+1)*(8+E).
- R9: In slave mode the serial clock output stays high and bits are shifted on edges of the external clock. The interrupt comes no more than 4 system clocks after the 8th rising external edge, whatever the interval and enables are set to.
- R10: The busy flag sets on the edge that accepts a start and clears on the edge that raises the interrupt. A start pulse that arrives while busy is ignored.
- R11: The interrupt is a single-cycle pulse, and the serial clock stays high during every gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | 1: drive the serial clock; 0: slave, follow sck_in |
| auto_en | input | 1 | 1: multi-byte burst of byte_cnt+1 bytes |
| strobe_en | input | 1 | Strobe enable; raises the gap floor to 2 |
| busy_en | input | 1 | Busy enable; raises the gap floor to 1 |
| clk_div | input | 8 | Divisor D; half serial period is D+1 clocks |
| byte_cnt | input | 4 | Burst length minus one (automatic mode) |
| start | input | 1 | Start request, taken while idle |
| tx_data | input | 8 | Byte to send, taken at each byte load |
| cfg_wr_en | input | 1 | Interval register write strobe |
| cfg_wr_data | input | 6 | Interval value to write |
| gap_rd | output | 8 | Interval register readback |
| xfer_busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion pulse |
| rx_data | output | 8 | Last byte received |
| sck_out | output | 1 | Serial clock output, idles high |
| sdo | output | 1 | Serial data out |
| sck_in | input | 1 | External serial clock (slave mode) |
| sdi | input | 1 | Serial data in |

## Verification
The interrupt is due a fixed number of edges after the accepting edge S: 2*(D+1)*(8+E) per byte, times N in a burst. The bench counts falling clock edges from S and requires the first interrupt to appear at exactly that count. One negedge later the pulse must be gone, the busy flag must be low and the serial clock must be high. Register readback is sampled one negedge after the write edge. Slave completion is counted from the negedge that drives the 8th rising external edge and must arrive within 4 clocks.

// File: rtl/sio_gap_pkg.sv
// Package: shared transfer states and gap floors for the serial gap master.
package sio_gap_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP} xfer_st_e;
    localparam int STB_FLOOR = 2;
    localparam int BSY_FLOOR = 1;
endpackage

// File: rtl/sio_baud_gen.sv
// sio_baud_gen: emits one tick every DIV+1 system clocks while run is high.
// A tick marks one serial half-period. The count restarts whenever run drops,
// so the first tick after run rises lands DIV+1 clocks later.
module sio_baud_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    // Half-period counter: clears when idle or on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sio_edge_sync.sv
// sio_edge_sync: brings the external serial clock into the clk domain and
// flags its edges. Assumes the external clock is slower than clk/4.
module sio_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    output logic s_rise,
    output logic s_fall
);
    logic [2:0] sync_q;

    // Three-stage shift: two to settle, one to compare for edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= 3'b111;
        else
            sync_q <= {sync_q[1:0], sck_in};
    end

    assign s_rise = sync_q[1] && !sync_q[2];
    assign s_fall = !sync_q[1] && sync_q[2];
endmodule

// File: rtl/sio_shifter.sv
// sio_shifter: MSB-first shift register. Assumes load, fall_ev and rise_ev
// are mutually exclusive. Data out updates on falling events, data in is
// taken on rising events, and the finished byte is captured at byte_end.
module sio_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              fall_ev,
    input  logic              rise_ev,
    input  logic              byte_end,
    input  logic              sdi,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] sh_next;

    assign sh_next = {sh_q[DATA_W-2:0], sdi};

    // Shift register: load a byte or shift in one bit per rising event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (load)
            sh_q <= load_data;
        else if (rise_ev)
            sh_q <= sh_next;
    end

    // Data-out line: presents the current MSB on each falling event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sdo <= 1'b1;
        else if (fall_ev)
            sdo <= sh_q[DATA_W-1];
    end

    // Receive capture: keeps the completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_data <= '0;
        else if (byte_end)
            rx_data <= sh_next;
    end

    a_r5_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_ev |=> $stable(sdo))
        else $error("R5: data out changed without a falling event");
endmodule

// File: rtl/sio_gap_ctrl.sv
// sio_gap_ctrl: transfer sequencer. It toggles the master serial clock on
// baud ticks, counts the bits of each byte, then counts the inter-byte gap
// in serial periods (two ticks each). When the gap ends it starts the next
// burst byte or raises the completion pulse. In slave mode the gap is zero.
module sio_gap_ctrl
    import sio_gap_pkg::*;
#(
    parameter int GAP_W  = 6,
    parameter int CNT_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic             auto_en,
    input  logic             strobe_en,
    input  logic             busy_en,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [GAP_W-1:0] gap_val,
    input  logic             tick,
    input  logic             s_rise,
    input  logic             s_fall,
    output logic             run,
    output logic             sck_o,
    output logic             busy_o,
    output logic             irq_o,
    output logic             load_o,
    output logic             fall_ev,
    output logic             rise_ev,
    output logic             byte_end
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam int GT_W  = GAP_W + 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    xfer_st_e         st_q;
    logic [BIT_W-1:0] bit_q;
    logic [CNT_W-1:0] left_q;
    logic [GT_W-1:0]  gt_q;
    logic [GAP_W-1:0] floor_gap;
    logic [GAP_W-1:0] eff_gap;
    logic             gap_done;

    // Gap floor from the strobe and busy enables; strobe dominates.
    always_comb begin
        if (strobe_en)
            floor_gap = GAP_W'(STB_FLOOR);
        else if (busy_en)
            floor_gap = GAP_W'(BSY_FLOOR);
        else
            floor_gap = '0;
    end

    // Effective gap: larger of interval and floor, none in slave mode.
    assign eff_gap = !master_en ? '0 : ((gap_val > floor_gap) ? gap_val : floor_gap);

    assign run      = master_en && (st_q != ST_IDLE);
    assign fall_ev  = (st_q == ST_XFER) && (master_en ? (tick && sck_o) : s_fall);
    assign rise_ev  = (st_q == ST_XFER) && (master_en ? (tick && !sck_o) : s_rise);
    assign byte_end = rise_ev && (bit_q == LAST_BIT);
    assign gap_done = (byte_end && (eff_gap == '0)) ||
                      ((st_q == ST_GAP) && tick && (gt_q == GT_W'(1)));
    assign load_o   = ((st_q == ST_IDLE) && start) || (gap_done && (left_q != '0));

    // Sequencer: state, serial clock, bit/byte/gap counters, busy and pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sck_o  <= 1'b1;
            busy_o <= 1'b0;
            irq_o  <= 1'b0;
            bit_q  <= '0;
            left_q <= '0;
            gt_q   <= '0;
        end else begin
            irq_o <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    sck_o <= 1'b1;
                    if (start) begin
                        st_q   <= ST_XFER;
                        busy_o <= 1'b1;
                        bit_q  <= '0;
                        left_q <= auto_en ? byte_cnt : '0;
                    end
                end
                ST_XFER: begin
                    if (master_en && tick)
                        sck_o <= !sck_o;
                    if (rise_ev)
                        bit_q <= bit_q + 1'b1;
                    if (byte_end) begin
                        bit_q <= '0;
                        if (eff_gap != '0) begin
                            st_q <= ST_GAP;
                            gt_q <= {eff_gap, 1'b0};
                        end
                    end
                end
                ST_GAP: begin
                    if (tick)
                        gt_q <= gt_q - 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
            if (gap_done) begin
                if (left_q != '0) begin
                    left_q <= left_q - 1'b1;
                    st_q   <= ST_XFER;
                end else begin
                    st_q   <= ST_IDLE;
                    busy_o <= 1'b0;
                    irq_o  <= 1'b1;
                end
            end
        end
    end

    a_r11_sck_high_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GAP) |-> sck_o)
        else $error("R11: serial clock low during gap");
    a_r11_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o)
        else $error("R11: interrupt wider than one cycle");
    a_r10_busy_clear_at_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !busy_o)
        else $error("R10: busy still set at interrupt");
    a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start))
        else $error("R10: busy set without start");
    a_r6_gap_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GAP) |-> (gt_q != '0))
        else $error("R6: gap state with empty counter");
endmodule

// File: rtl/sio_gap_master.sv
// sio_gap_master: top of the serial master with a programmable inter-byte
// gap. It holds the interval register (write-locked while busy) and wires
// the divider, slave edge synchronizer, sequencer and shifter together.
module sio_gap_master #(
    parameter int DIV_W  = 8,
    parameter int GAP_W  = 6,
    parameter int CNT_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              auto_en,
    input  logic              strobe_en,
    input  logic              busy_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              cfg_wr_en,
    input  logic [GAP_W-1:0]  cfg_wr_data,
    output logic [7:0]        gap_rd,
    output logic              xfer_busy,
    output logic              irq,
    output logic [DATA_W-1:0] rx_data,
    output logic              sck_out,
    output logic              sdo,
    input  logic              sck_in,
    input  logic              sdi
);
    localparam int REG_W = 8;

    logic [GAP_W-1:0] gap_q;
    logic tick, run, s_rise, s_fall, load, fall_ev, rise_ev, byte_end;

    // Interval register: takes writes only while no transfer is running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (cfg_wr_en && !xfer_busy)
            gap_q <= cfg_wr_data;
    end

    assign gap_rd = {{(REG_W - GAP_W){1'b0}}, gap_q};

    sio_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .div(clk_div), .tick(tick)
    );

    sio_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .s_rise(s_rise), .s_fall(s_fall)
    );

    sio_gap_ctrl #(.GAP_W(GAP_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .auto_en(auto_en),
        .strobe_en(strobe_en), .busy_en(busy_en), .start(start),
        .byte_cnt(byte_cnt), .gap_val(gap_q), .tick(tick), .s_rise(s_rise),
        .s_fall(s_fall), .run(run), .sck_o(sck_out), .busy_o(xfer_busy),
        .irq_o(irq), .load_o(load), .fall_ev(fall_ev), .rise_ev(rise_ev),
        .byte_end(byte_end)
    );

    sio_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(tx_data),
        .fall_ev(fall_ev), .rise_ev(rise_ev), .byte_end(byte_end), .sdi(sdi),
        .sdo(sdo), .rx_data(rx_data)
    );

    a_r3_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && xfer_busy) |=> $stable(gap_q))
        else $error("R3: interval changed while busy");
    a_r9_slave_clock_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && sck_out) |=> sck_out)
        else $error("R9: serial clock driven in slave mode");
endmodule

// File: tb/sio_gap_master_bench.sv
// Bench for sio_gap_master: directed corners plus seeded random transfers.
module sio_gap_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b1, auto_en = 1'b0, strobe_en = 1'b0, busy_en = 1'b0;
    logic [7:0] clk_div = '0;
    logic [3:0] byte_cnt = '0;
    logic       start = 1'b0;
    logic [7:0] tx_data = '0;
    logic       cfg_wr_en = 1'b0;
    logic [5:0] cfg_wr_data = '0;
    logic [7:0] gap_rd, rx_data;
    logic       xfer_busy, irq, sck_out, sdo;
    logic       sck_in = 1'b1;
    logic       slv_bit = 1'b0;
    logic       sdi;
    logic [7:0] mon_byte = '0;
    int         n_tests = 0;
    int         n_fail = 0;

    assign sdi = master_en ? sdo : slv_bit;

    always #5 clk = !clk;

    sio_gap_master u_sio_gap_master (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .auto_en(auto_en),
        .strobe_en(strobe_en), .busy_en(busy_en), .clk_div(clk_div),
        .byte_cnt(byte_cnt), .start(start), .tx_data(tx_data),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .gap_rd(gap_rd),
        .xfer_busy(xfer_busy), .irq(irq), .rx_data(rx_data), .sck_out(sck_out),
        .sdo(sdo), .sck_in(sck_in), .sdi(sdi)
    );

    // Collects the bits on the line at each rising serial clock.
    always @(posedge sck_out) mon_byte <= {mon_byte[6:0], sdo};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_gap(input int iv, input bit stb, input bit bsy);
        int fl;
        fl = stb ? 2 : (bsy ? 1 : 0);
        return (iv > fl) ? iv : fl;
    endfunction

    function automatic int exp_lat(input int d, input int e, input bit au, input int bc);
        return (au ? bc + 1 : 1) * 2 * (d + 1) * (8 + e);
    endfunction

    task automatic cfg_write(input int v);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_data = 6'(v);
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Runs one master transfer and checks timing, data and flags.
    task automatic run_xfer(input int d, input int iv, input bit stb, input bit bsy,
                            input bit au, input int bc, input logic [7:0] txd,
                            input bit disturb, input string tag);
        int n;
        int exp;
        @(negedge clk);
        master_en = 1'b1; clk_div = 8'(d); strobe_en = stb; busy_en = bsy;
        auto_en = au; byte_cnt = 4'(bc); tx_data = txd; start = 1'b1;
        exp = exp_lat(d, exp_gap(iv, stb, bsy), au, bc);
        @(posedge clk);
        n = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (n == 0) check(xfer_busy == 1'b1, {tag, " R10 busy set"}, int'(xfer_busy), 1);
            if (disturb) begin
                cfg_wr_en = (n == 2);
                cfg_wr_data = 6'(~iv);
                start = (n == 4);
            end
            if (irq || n > 20000) break;
            n++;
        end
        cfg_wr_en = 1'b0;
        start = 1'b0;
        check(n == exp, {tag, " R4 interrupt latency"}, n, exp);
        check(xfer_busy == 1'b0, {tag, " R10 busy clear"}, int'(xfer_busy), 0);
        check(rx_data == txd, {tag, " R5 receive byte"}, int'(rx_data), int'(txd));
        check(mon_byte == txd, {tag, " R5 line order"}, int'(mon_byte), int'(txd));
        check(sck_out == 1'b1, {tag, " R11 clock idle"}, int'(sck_out), 1);
        @(negedge clk);
        check(irq == 1'b0, {tag, " R11 pulse width"}, int'(irq), 0);
        if (disturb) begin
            check(gap_rd == 8'(iv), {tag, " R3 locked write"}, int'(gap_rd), iv);
            repeat (2 * (d + 1) * 10) @(negedge clk);
            check(xfer_busy == 1'b0 && irq == 1'b0, {tag, " R10 late start ignored"},
                  int'(xfer_busy), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int iv;
        int seed;
        seed = int'($urandom(32'd4021));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(gap_rd == 8'h00, "R1 interval", int'(gap_rd), 0);
        check(!xfer_busy && !irq, "R1 busy/irq", int'(xfer_busy), 0);
        check(sck_out == 1'b1, "R1 clock idle", int'(sck_out), 1);
        // R2 write and readback
        cfg_write(63);
        check(gap_rd == 8'h3F, "R2 readback upper bits zero", int'(gap_rd), 63);
        cfg_write(5);
        check(gap_rd == 8'h05, "R2 readback", int'(gap_rd), 5);
        // R7 zero-wait
        cfg_write(0);
        run_xfer(0, 0, 0, 0, 0, 0, 8'hA5, 0, "R7 zero wait");
        run_xfer(2, 0, 0, 0, 1, 2, 8'h3C, 0, "R7 R8 zero wait burst");
        // R6 floors overriding a zero interval
        run_xfer(1, 0, 1, 0, 0, 0, 8'h81, 0, "R6 strobe floor");
        run_xfer(1, 0, 0, 1, 0, 0, 8'h7E, 0, "R6 busy floor");
        run_xfer(0, 0, 1, 1, 0, 0, 8'hC3, 0, "R6 both floor");
        cfg_write(1);
        run_xfer(0, 1, 1, 0, 0, 0, 8'h12, 0, "R6 floor above interval");
        // R8 burst with large interval
        cfg_write(63);
        run_xfer(1, 63, 0, 0, 1, 1, 8'hF0, 0, "R8 long gap burst");
        // R3 and R10: write and start during a transfer
        cfg_write(9);
        run_xfer(1, 9, 0, 1, 0, 0, 8'h5A, 1, "R3 R10 disturb");
        // Seeded random transfers
        for (int t = 0; t < 24; t++) begin
            iv = int'($urandom_range(0, 63));
            cfg_write(iv);
            run_xfer(int'($urandom_range(0, 3)), iv, 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     int'($urandom_range(0, 3)), 8'($urandom_range(0, 255)),
                     t % 6 == 0, "R4 random");
        end
        // R9 slave mode: gap and floors bypassed, clock output idle
        begin
            logic [7:0] sb;
            int n;
            bit clk_low;
            sb = 8'h96;
            clk_low = 1'b0;
            cfg_write(63);
            @(negedge clk);
            master_en = 1'b0; strobe_en = 1'b1; busy_en = 1'b1; auto_en = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int b = 7; b >= 0; b--) begin
                sck_in = 1'b0;
                slv_bit = sb[b];
                repeat (4) begin @(negedge clk); if (!sck_out) clk_low = 1'b1; end
                sck_in = 1'b1;
                if (b != 0) repeat (4) begin @(negedge clk); if (!sck_out) clk_low = 1'b1; end
            end
            n = 0;
            forever begin
                @(negedge clk);
                if (irq || n > 10) break;
                n++;
            end
            check(n <= 4, "R9 slave interrupt latency", n, 4);
            check(rx_data == sb, "R9 slave receive", int'(rx_data), int'(sb));
            check(!clk_low, "R9 clock output idle", int'(clk_low), 0);
            check(!xfer_busy, "R9 R10 busy clear", int'(xfer_busy), 0);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule